// File: doc/BRIEF.md
# Fractional Sample-Rate Clock Divider

This block runs in a single clock domain, driven by the master clock. It first derives a system-clock enable from that clock, with a divide of 1 or 2. It then produces two independent sample-rate strobes, one for the ADC path and one for the DAC path. Each strobe marks a subset of the system-clock enable cycles. Over the long run, each strobe's rate equals the system-clock rate divided by the ratio its rate code selects. Half-integer ratios are built by spreading two strobes over an odd number of enables.

Control changes are applied safely. A rate-code change waits for the current strobe period to complete. A reserved rate code is refused: the block keeps the prior ratio and raises a sticky error flag. A reserved pre-divide code is also ignored. The invert control moves the divide-by-2 enable onto the opposite master-clock phase.

Top module: `srate_div`

## Requirements
- R1: After reset, `sys_en` is high on every cycle. Both strobes fire on every enable, which is ratio 1.0. Both error flags are low.
- R2: A pre-divide code of 00 makes `sys_en` high on every cycle. A code of 10 makes `sys_en` high on every other cycle. Either code takes effect from the cycle after the first clock edge that samples it.
- R3: Pre-divide codes 01 and 11 are reserved and leave the current divide unchanged.
- R4: With divide-by-2 active, `clk_inv`=1 moves `sys_en` to the opposite phase within the same cycle. With divide-by-1, `clk_inv` has no effect.
- R5: A strobe is only ever high in a cycle where `sys_en` is high.
- R6: Rate codes 000, 010, 011, 100 and 110 select ratios 1, 2, 3, 4 and 6. At these ratios, exactly one strobe appears every N enables, with constant spacing.
- R7: Rate code 001 selects ratio 1.5. Counted from a fresh start, the pattern over each 3 enables is: no strobe, strobe, strobe.
- R8: Rate code 101 selects ratio 5.5. The strobes land on the 6th and 11th enable of every 11.
- R9: A new valid rate code is loaded only on a strobe of the old ratio. Counting under the new ratio starts afresh with the next enable.
- R10: Rate code 111 is reserved. It keeps the prior ratio. The matching error flag goes high from the next cycle and stays high until reset.
- R11: The ADC and DAC dividers are independent. A code on one of them never alters the other's strobes or error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Pre-divide select: 00 = /1, 10 = /2, others reserved |
| clk_inv | input | 1 | Master-clock polarity invert |
| adc_code | input | 3 | ADC rate code |
| dac_code | input | 3 | DAC rate code |
| sys_en | output | 1 | System-clock enable |
| adc_stb | output | 1 | ADC sample-rate strobe |
| dac_stb | output | 1 | DAC sample-rate strobe |
| adc_err | output | 1 | Sticky flag: reserved ADC rate code seen |
| dac_err | output | 1 | Sticky flag: reserved DAC rate code seen |

## Verification
`sys_en` and both strobes are combinational functions of registered state plus `clk_inv`, so they are due in the same cycle as the state that produces them. A change on `clk_inv` shows up at once. Changes to the pre-divide code, the rate codes and the error flags are due one clock edge after they are sampled. The bench changes inputs just after a rising edge. At each falling edge, a reference model predicts the outputs for that cycle and pushes them into a queue, then advances its own state using the inputs the next edge will sample. The monitor pops that entry and compares it in the same falling-edge slot.

// File: rtl/srate_div.sv
`timescale 1ns/1ps
module srate_div #(
  parameter int CW = 3,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pre_sel,
  input  logic          clk_inv,
  input  logic [CW-1:0] adc_code,
  input  logic [CW-1:0] dac_code,
  output logic          sys_en,
  output logic          adc_stb,
  output logic          dac_stb,
  output logic          adc_err,
  output logic          dac_err
);
  localparam logic [CW-1:0] RSV = '1;
  localparam logic [AW:0]   STEP = 2;

  logic div2, ph;
  logic [1:0][CW-1:0] code;
  logic [1:0] stb, err;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div2 <= 1'b0;
      ph   <= 1'b0;
    end else begin
      ph <= ~ph;
      if (pre_sel == 2'b00)      div2 <= 1'b0;
      else if (pre_sel == 2'b10) div2 <= 1'b1;
    end

  assign sys_en = div2 ? (ph ^ clk_inv) : 1'b1;
  assign code   = {dac_code, adc_code};

  function automatic logic [AW-1:0] half_steps(input logic [CW-1:0] c);
    case (c)
      3'd0:    return 4'd2;
      3'd1:    return 4'd3;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      3'd5:    return 4'd11;
      default: return 4'd12;
    endcase
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [AW-1:0] lim, acc, want;
    logic [AW:0]   nxt;
    logic          ok, hit, err_q;

    assign want = half_steps(code[g]);
    assign ok   = code[g] != RSV;
    assign nxt  = {1'b0, acc} + STEP;
    assign hit  = sys_en && (nxt >= {1'b0, lim});

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lim   <= 4'd2;
        acc   <= '0;
        err_q <= 1'b0;
      end else begin
        if (!ok) err_q <= 1'b1;
        if (sys_en) begin
          if (hit) begin
            if (ok && want != lim) begin
              lim <= want;
              acc <= '0;
            end else begin
              acc <= AW'(nxt - {1'b0, lim});
            end
          end else begin
            acc <= nxt[AW-1:0];
          end
        end
      end

    assign stb[g] = hit;
    assign err[g] = err_q;
  end

  assign adc_stb = stb[0];
  assign dac_stb = stb[1];
  assign adc_err = err[0];
  assign dac_err = err[1];
endmodule

module srate_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pre_sel,
  input logic [2:0] adc_code,
  input logic [2:0] dac_code,
  input logic       sys_en,
  input logic       adc_stb,
  input logic       dac_stb,
  input logic       adc_err,
  input logic       dac_err
);
  // R5
  adc_stb_in_en_chk: assert property (@(posedge clk) disable iff (!rst_n) adc_stb |-> sys_en);
  // R5
  dac_stb_in_en_chk: assert property (@(posedge clk) disable iff (!rst_n) dac_stb |-> sys_en);
  // R2
  div1_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) (pre_sel == 2'b00) |=> sys_en);
  // R10
  adc_rsv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) (adc_code == 3'b111) |=> adc_err);
  // R10
  dac_rsv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) (dac_code == 3'b111) |=> dac_err);
  // R10
  adc_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) adc_err |=> adc_err);
  // R10
  dac_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) dac_err |=> dac_err);
endmodule

bind srate_div srate_div_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .adc_code(adc_code), .dac_code(dac_code),
  .sys_en(sys_en), .adc_stb(adc_stb), .dac_stb(dac_stb), .adc_err(adc_err), .dac_err(dac_err)
);

// File: tb/test_srate_div.sv
`timescale 1ns/1ps
module test_srate_div;
  logic clk = 1'b0, rst_n = 1'b0, clk_inv = 1'b0;
  logic [1:0] pre_sel = 2'b00;
  logic [2:0] adc_code = 3'd0, dac_code = 3'd0;
  logic sys_en, adc_stb, dac_stb, adc_err, dac_err;
  int vectors = 0, errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  srate_div i_srate_div (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .clk_inv(clk_inv),
    .adc_code(adc_code), .dac_code(dac_code), .sys_en(sys_en),
    .adc_stb(adc_stb), .dac_stb(dac_stb), .adc_err(adc_err), .dac_err(dac_err)
  );

  typedef struct packed {logic s; logic a; logic d; logic ae; logic de;} exp_t;
  exp_t sbq[$];

  logic m_div2, m_ph;
  int   m_lim[2], m_n[2];
  logic m_err[2];

  function automatic int hs(input logic [2:0] c);
    case (c)
      3'd0: return 2;   3'd1: return 3;  3'd2: return 4;  3'd3: return 6;
      3'd4: return 8;   3'd5: return 11; default: return 12;
    endcase
  endfunction

  function automatic logic fires(input int n, input int lim);
    return ((2 * (n + 1)) / lim) > ((2 * n) / lim);
  endfunction

  task automatic predict();
    exp_t e;
    logic [2:0] cd[2];
    logic se;
    cd[0] = adc_code;
    cd[1] = dac_code;
    se = m_div2 ? (m_ph ^ clk_inv) : 1'b1;
    e.s = se; e.ae = m_err[0]; e.de = m_err[1];
    for (int i = 0; i < 2; i++) begin
      logic f;
      f = se && fires(m_n[i], m_lim[i]);
      if (i == 0) e.a = f; else e.d = f;
      if (se) begin
        if (f && cd[i] != 3'd7 && hs(cd[i]) != m_lim[i]) begin
          m_lim[i] = hs(cd[i]);
          m_n[i] = 0;
        end else m_n[i] = m_n[i] + 1;
      end
      if (cd[i] == 3'd7) m_err[i] = 1'b1;
    end
    if (pre_sel == 2'b00) m_div2 = 1'b0;
    else if (pre_sel == 2'b10) m_div2 = 1'b1;
    m_ph = ~m_ph;
    sbq.push_back(e);
  endtask

  task automatic monitor();
    exp_t e, got;
    got = {sys_en, adc_stb, dac_stb, adc_err, dac_err};
    e = sbq.pop_front();
    vectors++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got {en,adc,dac,aerr,derr}=%b expected %b at %0t", cur_req, got, e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_div2 = 1'b0; m_ph = 1'b0;
      for (int i = 0; i < 2; i++) begin m_lim[i] = 2; m_n[i] = 0; m_err[i] = 1'b0; end
    end else begin
      predict();
      monitor();
    end
  end

  task automatic apply(input string req, input logic [1:0] p, input logic inv,
                       input logic [2:0] a, input logic [2:0] d, input int n);
    @(posedge clk); #2;
    cur_req = req; pre_sel = p; clk_inv = inv; adc_code = a; dac_code = d;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    apply("R1", 2'b00, 1'b0, 3'd0, 3'd0, 8);
    apply("R6", 2'b00, 1'b0, 3'd2, 3'd4, 40);
    apply("R6", 2'b00, 1'b0, 3'd3, 3'd6, 50);
    apply("R7", 2'b00, 1'b0, 3'd1, 3'd6, 40);
    apply("R8", 2'b00, 1'b0, 3'd1, 3'd5, 60);
    apply("R9", 2'b00, 1'b0, 3'd6, 3'd0, 3);
    apply("R9", 2'b00, 1'b0, 3'd4, 3'd3, 5);
    apply("R9", 2'b00, 1'b0, 3'd2, 3'd1, 30);
    apply("R2", 2'b10, 1'b0, 3'd0, 3'd3, 30);
    apply("R4", 2'b10, 1'b1, 3'd0, 3'd3, 20);
    apply("R5", 2'b10, 1'b0, 3'd1, 3'd5, 60);
    apply("R3", 2'b01, 1'b0, 3'd1, 3'd5, 20);
    apply("R3", 2'b11, 1'b1, 3'd1, 3'd5, 20);
    apply("R2", 2'b00, 1'b1, 3'd2, 3'd4, 30);
    apply("R4", 2'b00, 1'b0, 3'd2, 3'd4, 20);
    apply("R3", 2'b11, 1'b0, 3'd2, 3'd4, 20);
    apply("R10", 2'b00, 1'b0, 3'd7, 3'd4, 30);
    apply("R11", 2'b00, 1'b0, 3'd5, 3'd4, 40);
    apply("R10", 2'b00, 1'b0, 3'd5, 3'd7, 30);
    apply("R10", 2'b10, 1'b0, 3'd3, 3'd2, 40);
    @(posedge clk); #2;
    finish_run();
  end
endmodule